// File: doc/BRIEF.md
# Edge-Selectable Saturating Event Counter

This block counts edges on an external, asynchronous event input with a 16-bit counter. A control bit selects which edge counts: rising or falling. The input passes through a two-flop synchroniser and then an edge detector. Each qualifying edge adds exactly one to the count. The count saturates at FFFFh and never wraps. Software must preset or clear it before counting can continue.

Software uses a parallel byte register port, with three registers. The control register at 0Dh holds the edge polarity in bit 0, the write-mode flag in bit 2 and the snapshot request in bit 3. Registers 0Eh and 0Fh hold the low and high count bytes. Reads of the count bytes always return a holding register (the snapshot), so the two bytes of a count are coherent even while edges keep arriving. A 0-to-1 write of the snapshot bit copies the live count into the holding register. Write mode stops counting and lets byte writes preset the live count. Leaving write mode reloads the snapshot from the live count.

Top module: `evt_counter`

## Requirements
- R1: After reset, register 0Dh reads 00h and registers 0Eh and 0Fh read 00h; the polarity is falling edge, write mode is off and the count is zero.
- R2: With bit 0 of 0Dh at 0, each falling edge of the event input adds 1 to the count, and rising edges add nothing.
- R3: With bit 0 of 0Dh at 1, each rising edge of the event input adds 1 to the count, and falling edges add nothing.
- R4: A write to 0Dh that changes bit 3 from 0 to 1 copies the live count into the snapshot. Reads of 0Eh (bits 7:0) and 0Fh (bits 15:8) return that snapshot unchanged, even when edges arrive afterwards.
- R5: Bit 3 of 0Dh reads back as written. Writing 1 while it is already 1 does not refresh the snapshot. The bit must be written to 0 and then to 1 again.
- R6: While bit 2 of 0Dh is 1, edges on the event input do not change the count.
- R7: While bit 2 of 0Dh is 1, a write to 0Eh or 0Fh replaces that byte of the live count. A write that clears bit 2 also reloads the snapshot from the live count, so the preset value reads back at once.
- R8: While bit 2 of 0Dh is 0, writes to 0Eh and 0Fh have no effect on the count.
- R9: At FFFFh the count holds; further edges do not roll it over to zero.
- R10: Bits 7:4 and bit 1 of 0Dh always read as 0, whatever is written to them.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| evt_in | input | 1 | Asynchronous event input |
| reg_addr | input | 8 | Register address for reads and writes |
| reg_wr | input | 1 | Write strobe, one cycle per write |
| reg_wdata | input | 8 | Write data |
| reg_rdata | output | 8 | Combinational read data for reg_addr |

## Verification
A change on the event input passes two synchroniser flops and an edge-history flop before it reaches the live count. The count therefore moves on the third rising clock edge after the input changes. The bench holds each input level for six cycles before it requests a snapshot. A register write is registered on the clock edge that ends its strobe cycle. Reads are combinational, so the bench reads one cycle after each write and samples half a period away from any active edge.

// File: rtl/evt_counter.sv
module evt_counter #(
  parameter logic [7:0] CTRL_ADDR = 8'h0D,
  parameter logic [7:0] LO_ADDR   = 8'h0E,
  parameter logic [7:0] HI_ADDR   = 8'h0F
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       evt_in,
  input  logic [7:0] reg_addr,
  input  logic       reg_wr,
  input  logic [7:0] reg_wdata,
  output logic [7:0] reg_rdata
);
  localparam int CW = 16;
  localparam logic [CW-1:0] FULL = '1;

  logic [2:0]    sync_q;
  logic          pol_q, wmode_q, snap_q;
  logic [CW-1:0] cnt_q, hold_q;

  wire ctrl_wr = reg_wr && reg_addr == CTRL_ADDR;
  wire lo_wr   = reg_wr && wmode_q && reg_addr == LO_ADDR;
  wire hi_wr   = reg_wr && wmode_q && reg_addr == HI_ADDR;
  wire cnt_wr  = lo_wr || hi_wr;
  wire hit     = pol_q ? (sync_q[1] & ~sync_q[2]) : (~sync_q[1] & sync_q[2]);
  wire bump    = hit && !wmode_q && cnt_q != FULL;
  wire hold_ld = ctrl_wr && ((reg_wdata[3] && !snap_q) || (!reg_wdata[2] && wmode_q));

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sync_q  <= '0;
      pol_q   <= 1'b0;
      wmode_q <= 1'b0;
      snap_q  <= 1'b0;
      cnt_q   <= '0;
      hold_q  <= '0;
    end else begin
      sync_q <= {sync_q[1:0], evt_in};
      if (ctrl_wr) begin
        pol_q   <= reg_wdata[0];
        wmode_q <= reg_wdata[2];
        snap_q  <= reg_wdata[3];
      end
      if (hold_ld) hold_q <= cnt_q;
      if (lo_wr)      cnt_q[7:0]  <= reg_wdata;
      else if (hi_wr) cnt_q[15:8] <= reg_wdata;
      else if (bump)  cnt_q       <= cnt_q + 1'b1;
    end
  end

  always_comb begin
    case (reg_addr)
      CTRL_ADDR: reg_rdata = {4'b0, snap_q, wmode_q, 1'b0, pol_q};
      LO_ADDR:   reg_rdata = hold_q[7:0];
      HI_ADDR:   reg_rdata = hold_q[15:8];
      default:   reg_rdata = 8'h00;
    endcase
  end

  assert_saturate_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt_q == FULL && !cnt_wr) |=> cnt_q == FULL);

  assert_blocked_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (wmode_q && !cnt_wr) |=> $stable(cnt_q));

  assert_step_one_R2: assert property (@(posedge clk) disable iff (!rst_n)
    !cnt_wr |=> (cnt_q == $past(cnt_q) || cnt_q == $past(cnt_q) + 1'b1));

  assert_hold_stable_R4: assert property (@(posedge clk) disable iff (!rst_n)
    !ctrl_wr |=> $stable(hold_q));

  assert_ignored_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (!wmode_q && !hit) |=> $stable(cnt_q));
endmodule

// File: tb/evt_counter_bench.sv
module evt_counter_bench;
  logic       clk = 1'b0;
  logic       rst_n = 1'b0;
  logic       evt_in = 1'b0;
  logic [7:0] reg_addr = 8'h00;
  logic       reg_wr = 1'b0;
  logic [7:0] reg_wdata = 8'h00;
  logic [7:0] reg_rdata;

  int compared = 0;
  int mismatched = 0;
  int cyc = 0;

  evt_counter u_evt_counter (
    .clk(clk), .rst_n(rst_n), .evt_in(evt_in), .reg_addr(reg_addr),
    .reg_wr(reg_wr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata)
  );

  always #5 clk = ~clk;

  localparam int NV = 6;
  localparam logic        V_POL [NV] = '{1'b0, 1'b1, 1'b0, 1'b1, 1'b1, 1'b0};
  localparam int          V_N   [NV] = '{5, 7, 3, 2, 4, 1};
  localparam logic [15:0] V_PRE [NV] = '{16'h0000, 16'h0000, 16'h00FE, 16'h1234, 16'hFFFD, 16'hFFFF};
  localparam logic [15:0] V_EXP [NV] = '{16'h0005, 16'h0007, 16'h0101, 16'h1236, 16'hFFFF, 16'hFFFF};

  task automatic wr(input logic [7:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic chk(input logic [7:0] a, input logic [7:0] exp, input string req);
    reg_addr = a;
    #1;
    compared++;
    if (reg_rdata !== exp) begin
      mismatched++;
      $display("FAIL %s addr %h: got %h expected %h", req, a, reg_rdata, exp);
    end
  endtask

  task automatic chk16(input logic [15:0] exp, input string req);
    chk(8'h0E, exp[7:0], req);
    chk(8'h0F, exp[15:8], req);
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic pulse(input logic pol, input int n);
    for (int i = 0; i < n; i++) begin
      evt_in = pol; idle(6);
      evt_in = ~pol; idle(6);
    end
  endtask

  task automatic snap(input logic pol);
    wr(8'h0D, {4'b0, 1'b0, 1'b0, 1'b0, pol});
    wr(8'h0D, {4'b0, 1'b1, 1'b0, 1'b0, pol});
  endtask

  task automatic finish_run();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  endtask

  always @(posedge clk) begin
    cyc++;
    if (cyc > 100000) begin
      mismatched++;
      compared++;
      $display("FAIL watchdog: got timeout expected completion");
      finish_run();
    end
  end

  initial begin
    idle(3);
    rst_n = 1'b1;
    idle(1);
    // R1 reset state
    chk(8'h0D, 8'h00, "R1");
    chk16(16'h0000, "R1");

    // R2 R3 R7 R9 vector walk
    for (int v = 0; v < NV; v++) begin
      wr(8'h0D, {4'b0, 1'b0, 1'b1, 1'b0, V_POL[v]});
      evt_in = ~V_POL[v];
      idle(6);
      wr(8'h0E, V_PRE[v][7:0]);
      wr(8'h0F, V_PRE[v][15:8]);
      wr(8'h0D, {4'b0, 1'b0, 1'b0, 1'b0, V_POL[v]});
      chk16(V_PRE[v], "R7");
      pulse(V_POL[v], V_N[v]);
      snap(V_POL[v]);
      chk16(V_EXP[v], V_EXP[v] == 16'hFFFF ? "R9" : (V_POL[v] ? "R3" : "R2"));
    end

    // R10 unused bits
    wr(8'h0D, 8'hFF);
    chk(8'h0D, 8'h0D, "R10");

    // preset to zero, falling edge mode, idle high
    evt_in = 1'b1;
    idle(6);
    wr(8'h0E, 8'h00);
    wr(8'h0F, 8'h00);
    wr(8'h0D, 8'h00);
    chk16(16'h0000, "R7");

    // R4 snapshot stays while edges arrive
    pulse(1'b0, 3);
    snap(1'b0);
    chk16(16'h0003, "R4");
    pulse(1'b0, 2);
    chk16(16'h0003, "R4");

    // R5 rewriting 1 does not refresh
    wr(8'h0D, 8'h08);
    chk(8'h0D, 8'h08, "R5");
    chk16(16'h0003, "R5");
    snap(1'b0);
    chk16(16'h0005, "R5");

    // R6 write mode blocks counting
    wr(8'h0D, 8'h04);
    pulse(1'b0, 4);
    wr(8'h0D, 8'h00);
    chk16(16'h0005, "R6");

    // R8 byte writes ignored outside write mode
    wr(8'h0E, 8'h55);
    wr(8'h0F, 8'hAA);
    snap(1'b0);
    chk16(16'h0005, "R8");

    // R2 rising edge ignored in falling mode
    evt_in = 1'b0; idle(6);
    evt_in = 1'b1; idle(6);
    snap(1'b0);
    chk16(16'h0006, "R2");

    finish_run();
  end
endmodule